// File: doc/BRIEF.md
# Display RAM Host Bus Interface

This block connects an 8-bit parallel host bus to the frame memory of a small graphics display controller. The host selects the device with an active-low chip select, picks between memory data and command registers with a register-select line, and starts each access with a falling edge on an active-low read or write strobe. All inputs are taken to be synchronous to the block clock, and an access is recognised on the clock edge at which the strobe is first seen low.

Command writes set a 4-bit column (X) register, an 8-bit row (Y) register and a column-reverse flag. When the flag is set, the column sent to the memory is fifteen minus the register value. Memory writes store the bus byte at the current column and row. Memory reads pass through a one-stage latch. A read returns the byte the previous read fetched, so the first read after any column or row load is a throw-away that returns 0x00.

The memory holds 16 columns and 2^RAM_YW rows. The row is the low RAM_YW bits of the Y register.

Top module: `dram_host_port`

## Requirements
- R1: Strobe edges seen while `cs_n` is high cause no access. Memory, registers and the read latch all stay unchanged.
- R2: With `rs`=0 an access goes to the memory. A memory write never alters the column register, the row register or the read latch.
- R3: A memory write (`wr_n` falls while `rd_n` is high, `rs`=0) stores `din` at the current effective column and row.
- R4: A memory read (`rd_n` falls while `wr_n` is high, `rs`=0) puts on `dout` the byte held in the read latch. The latch then loads the memory byte at the current address, so a second read returns the addressed contents.
- R5: Any load of the column or row register clears the read latch. The next read returns 0x00.
- R6: A command byte with bits 7..4 = 0000 loads bits 3..0 into the column register.
- R7: Command byte 0x10 arms a row load. The next command byte of any value is then taken whole as the row register, and the memory row is that value's low RAM_YW bits.
- R8: Command bytes 0x20 and 0x21 clear and set the column-reverse flag. While the flag is set, the memory column is 0xF minus the column register.
- R9: Command bytes that match none of the codes in R6 to R8, with no row load armed, change no register and do not clear the read latch.
- R10: Reset clears the column register, the row register, the reverse flag and the read latch to zero.
- R11: `dout_en` is high only while `cs_n` and `rd_n` are both low. If both strobes fall together, no access takes place.
- R12: A strobe held low for many cycles performs exactly one access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_n | input | 1 | Chip select, active low |
| rs | input | 1 | 0 selects memory data, 1 selects command registers |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| din | input | 8 | Host write data |
| dout | output | 8 | Host read data |
| dout_en | output | 1 | High while the block drives `dout` |

## Verification
Reads are issued in pairs after every column or row load. A 0x00 followed by the stored byte shows that the latch is cleared and the pipeline advances. Cells are written with the reverse flag set and read back with it cleared, through the mirrored register value, which separates a true mirror from a pass-through. Undefined codes, deselected strobes, simultaneous strobes and memory writes of command-like bytes are each followed by a read whose value would change if a register or the latch had been touched. Long strobes, a mid-run reset and a row byte with high bits set test the single-access rule, the reset state and the row truncation.

// File: rtl/dram_hp_pkg.sv
package dram_hp_pkg;

  localparam int XW = 4;
  localparam int DW = 8;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_RAM_WR = 2'd1,
    ACC_RAM_RD = 2'd2,
    ACC_REG_WR = 2'd3
  } acc_e;

  localparam logic [3:0] CMD_COL_HI  = 4'h0;
  localparam logic [7:0] CMD_ROW_ARM = 8'h10;
  localparam logic [6:0] CMD_REV_HI  = 7'b0010000;

  function automatic logic [XW-1:0] col_map(input logic [XW-1:0] col, input logic rev);
    logic [XW-1:0] top;
    top = '1;
    return rev ? (top - col) : col;
  endfunction

endpackage

// File: rtl/dram_bus_decode.sv
module dram_bus_decode
  import dram_hp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rs,
  input  logic rd_n,
  input  logic wr_n,
  output acc_e acc_o
);

  logic wr_prev_q, rd_prev_q;
  logic wr_fall, rd_fall;
  acc_e acc_d;

  always_comb begin
    wr_fall = wr_prev_q & ~wr_n & rd_n;
    rd_fall = rd_prev_q & ~rd_n & wr_n;
    acc_d   = ACC_NONE;
    if (!cs_n) begin
      if (wr_fall)      acc_d = rs ? ACC_REG_WR : ACC_RAM_WR;
      else if (rd_fall) acc_d = rs ? ACC_NONE : ACC_RAM_RD;
    end
  end

  assign acc_o = acc_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev_q <= 1'b1;
      rd_prev_q <= 1'b1;
    end else begin
      wr_prev_q <= wr_n;
      rd_prev_q <= rd_n;
    end
  end

  p_cs_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> acc_o == ACC_NONE);

  p_both_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !wr_n) |-> acc_o == ACC_NONE);

  p_one_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o == ACC_RAM_WR || acc_o == ACC_REG_WR) |=> !(acc_o == ACC_RAM_WR || acc_o == ACC_REG_WR));

  p_one_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o == ACC_RAM_RD |=> acc_o != ACC_RAM_RD);

endmodule

// File: rtl/dram_cmd_regs.sv
module dram_cmd_regs
  import dram_hp_pkg::*;
#(
  parameter int YW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_i,
  input  logic [DW-1:0] din_i,
  output logic [XW-1:0] col_o,
  output logic [YW-1:0] row_o,
  output logic          rev_o,
  output logic          addr_load_o
);

  logic [XW-1:0] col_q, col_d;
  logic [YW-1:0] row_q, row_d;
  logic          rev_q, rev_d;
  logic          arm_q, arm_d;
  logic          load_d;
  logic          is_col, is_arm, is_rev;

  always_comb begin
    is_col = (din_i[7:4] == CMD_COL_HI);
    is_arm = (din_i == CMD_ROW_ARM);
    is_rev = (din_i[7:1] == CMD_REV_HI);
    col_d  = col_q;
    row_d  = row_q;
    rev_d  = rev_q;
    arm_d  = arm_q;
    load_d = 1'b0;
    if (reg_wr_i) begin
      if (arm_q) begin
        row_d  = YW'(din_i);
        arm_d  = 1'b0;
        load_d = 1'b1;
      end else if (is_col) begin
        col_d  = din_i[XW-1:0];
        load_d = 1'b1;
      end else if (is_arm) begin
        arm_d  = 1'b1;
      end else if (is_rev) begin
        rev_d  = din_i[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      rev_q <= 1'b0;
      arm_q <= 1'b0;
    end else if (reg_wr_i) begin
      col_q <= col_d;
      row_q <= row_d;
      rev_q <= rev_d;
      arm_q <= arm_d;
    end
  end

  assign col_o       = col_q;
  assign row_o       = row_q;
  assign rev_o       = rev_q;
  assign addr_load_o = load_d;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr_i |=> $stable(col_q) && $stable(row_q) && $stable(rev_q));

  p_undef_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !arm_q && din_i[7:4] != 4'h0 && din_i != 8'h10 && din_i[7:1] != 7'h10)
      |=> $stable(col_q) && $stable(row_q) && $stable(rev_q) && !$past(addr_load_o));

  p_col_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !arm_q && din_i[7:4] == 4'h0) |=> col_q == $past(din_i[3:0]));

  p_row_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && arm_q) |=> row_q == $past(YW'(din_i)) && $stable(col_q));

endmodule

// File: rtl/dram_read_pipe.sv
module dram_read_pipe
  import dram_hp_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_i,
  input  logic          inv_i,
  input  logic [DW-1:0] mem_q_i,
  output logic [DW-1:0] data_o
);

  logic [DW-1:0] latch_q, latch_d;
  logic [DW-1:0] out_q, out_d;
  logic          en;

  always_comb begin
    latch_d = latch_q;
    out_d   = out_q;
    if (inv_i) begin
      latch_d = '0;
    end else if (rd_i) begin
      out_d   = latch_q;
      latch_d = mem_q_i;
    end
    en = inv_i | rd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      out_q   <= '0;
    end else if (en) begin
      latch_q <= latch_d;
      out_q   <= out_d;
    end
  end

  assign data_o = out_q;

  p_pipe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> out_q == $past(latch_q));

  p_dummy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> latch_q == '0);

  p_out_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(out_q));

endmodule

// File: rtl/dram_store.sv
module dram_store
  import dram_hp_pkg::*;
#(
  parameter int RAM_YW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we_i,
  input  logic [RAM_YW+XW-1:0] addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o
);

  localparam int DEPTH = 1 << (RAM_YW + XW);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];

  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem[$past(addr_i)] == $past(wdata_i));

endmodule

// File: rtl/dram_host_port.sv
module dram_host_port
  import dram_hp_pkg::*;
#(
  parameter int YW     = 8,
  parameter int RAM_YW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rs,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       dout_en
);

  localparam int AW = RAM_YW + XW;

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  acc_e          acc;
  logic [XW-1:0] col_w;
  logic [YW-1:0] row_w;
  logic          rev_w;
  logic          addr_load;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  dram_bus_decode u_dec (
    .clk   (clk),
    .rst_n (rst_core_n),
    .cs_n  (cs_n),
    .rs    (rs),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .acc_o (acc)
  );

  dram_cmd_regs #(.YW(YW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .reg_wr_i    (acc == ACC_REG_WR),
    .din_i       (din),
    .col_o       (col_w),
    .row_o       (row_w),
    .rev_o       (rev_w),
    .addr_load_o (addr_load)
  );

  assign mem_addr = {row_w[RAM_YW-1:0], col_map(col_w, rev_w)};

  dram_store #(.RAM_YW(RAM_YW)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .we_i    (acc == ACC_RAM_WR),
    .addr_i  (mem_addr),
    .wdata_i (din),
    .rdata_o (mem_q)
  );

  dram_read_pipe u_pipe (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .rd_i    (acc == ACC_RAM_RD),
    .inv_i   (addr_load),
    .mem_q_i (mem_q),
    .data_o  (dout)
  );

  assign dout_en = ~cs_n & ~rd_n;

  p_row_src_r7: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(mem_addr[AW-1:XW]) |-> !$stable(row_w));

  p_col_src_r8: assert property (@(posedge clk) disable iff (!rst_core_n)
    !$stable(mem_addr[XW-1:0]) |-> (!$stable(col_w) || !$stable(rev_w)));

endmodule

// File: tb/sim_dram_host_port.sv
module sim_dram_host_port;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [2:0] OP_REG  = 3'd0;
  localparam logic [2:0] OP_WR   = 3'd1;
  localparam logic [2:0] OP_RD   = 3'd2;
  localparam logic [2:0] OP_NCRG = 3'd3;
  localparam logic [2:0] OP_NCWR = 3'd4;

  // {op, data, expected read, requirement number}
  localparam int NV = 37;
  localparam logic [22:0] VEC [NV] = '{
    {OP_REG,  8'h03, 8'h00, 4'd6},   // col = 3
    {OP_REG,  8'h10, 8'h00, 4'd7},   // arm row load
    {OP_REG,  8'h02, 8'h00, 4'd7},   // row = 2
    {OP_WR,   8'hA5, 8'h00, 4'd3},   // (3,2) = A5
    {OP_REG,  8'h05, 8'h00, 4'd6},
    {OP_WR,   8'h3C, 8'h00, 4'd3},   // (5,2) = 3C
    {OP_REG,  8'h03, 8'h00, 4'd6},
    {OP_RD,   8'h00, 8'h00, 4'd5},   // R5 throw-away read
    {OP_RD,   8'h00, 8'hA5, 4'd4},   // R4
    {OP_RD,   8'h00, 8'hA5, 4'd3},   // R3
    {OP_REG,  8'h21, 8'h00, 4'd8},   // reverse on, column C
    {OP_WR,   8'h77, 8'h00, 4'd8},   // (C,2) = 77
    {OP_REG,  8'h20, 8'h00, 4'd8},
    {OP_REG,  8'h0C, 8'h00, 4'd6},
    {OP_RD,   8'h00, 8'h00, 4'd5},
    {OP_RD,   8'h00, 8'h77, 4'd8},   // R8 mirrored write seen directly
    {OP_REG,  8'h21, 8'h00, 4'd8},
    {OP_REG,  8'h0A, 8'h00, 4'd6},   // mirrored to column 5
    {OP_RD,   8'h00, 8'h00, 4'd5},
    {OP_RD,   8'h00, 8'h3C, 4'd8},   // R8 mirrored read
    {OP_REG,  8'h47, 8'h00, 4'd9},
    {OP_REG,  8'h35, 8'h00, 4'd9},
    {OP_RD,   8'h00, 8'h3C, 4'd9},   // R9 nothing changed, latch kept
    {OP_NCRG, 8'h00, 8'h00, 4'd1},
    {OP_RD,   8'h00, 8'h3C, 4'd1},   // R1 latch not cleared
    {OP_NCWR, 8'hEE, 8'h00, 4'd1},
    {OP_REG,  8'h0A, 8'h00, 4'd6},
    {OP_RD,   8'h00, 8'h00, 4'd6},
    {OP_RD,   8'h00, 8'h3C, 4'd1},   // R1 memory not written
    {OP_REG,  8'h10, 8'h00, 4'd7},
    {OP_REG,  8'h1A, 8'h00, 4'd7},   // row 1A -> memory row 2
    {OP_RD,   8'h00, 8'h00, 4'd7},
    {OP_RD,   8'h00, 8'h3C, 4'd7},   // R7
    {OP_WR,   8'h03, 8'h00, 4'd2},   // command-like byte to memory
    {OP_RD,   8'h00, 8'h3C, 4'd2},   // R2 latch not cleared
    {OP_RD,   8'h00, 8'h03, 4'd2},   // R2 column unchanged
    {OP_RD,   8'h00, 8'h03, 4'd3}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rs, rd_n, wr_n;
  logic [7:0] din;
  logic [7:0] dout;
  logic       dout_en;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_host_port u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rd_n(rd_n), .wr_n(wr_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  // kind: 0 write, 1 read, 2 both strobes
  task automatic bus(input logic cs_v, input logic rs_v, input int kind,
                     input logic [7:0] d, input int hold,
                     output logic [7:0] got, output logic en);
    @(negedge clk);
    cs_n = cs_v; rs = rs_v; din = d;
    if (kind != 1) wr_n = 1'b0;
    if (kind != 0) rd_n = 1'b0;
    repeat (hold) @(negedge clk);
    got = dout; en = dout_en;
    wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] g;
    logic       e;
    cs_n = 1'b1; rs = 1'b0; rd_n = 1'b1; wr_n = 1'b1; din = '0;
    apply_reset();

    // R10 reset state
    check("R11 idle dout_en", {7'b0, dout_en}, 8'h00);
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R10 latch after reset", g, 8'h00);
    check("R11 dout_en during read", {7'b0, e}, 8'h01);
    bus(1'b0, 1'b0, 0, 8'h5A, 1, g, e);      // lands at (0,0)
    bus(1'b0, 1'b1, 0, 8'h00, 1, g, e);      // col = 0
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R10 throw-away", g, 8'h00);
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R10 column and row reset to zero", g, 8'h5A);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic [7:0] dv, ev;
      logic [3:0] rq;
      {op, dv, ev, rq} = VEC[i];
      case (op)
        OP_REG:  bus(1'b0, 1'b1, 0, dv, 1, g, e);
        OP_WR:   bus(1'b0, 1'b0, 0, dv, 1, g, e);
        OP_NCRG: bus(1'b1, 1'b1, 0, dv, 1, g, e);
        OP_NCWR: bus(1'b1, 1'b0, 0, dv, 1, g, e);
        default: begin
          bus(1'b0, 1'b0, 1, dv, 1, g, e);
          check($sformatf("R%0d vector %0d", rq, i), g, ev);
        end
      endcase
    end

    // R11 deselected read does not drive the bus
    bus(1'b1, 1'b0, 1, 8'h00, 1, g, e);
    check("R11 dout_en with cs high", {7'b0, e}, 8'h00);

    // R12 long read advances the pipeline once
    bus(1'b0, 1'b1, 0, 8'h0A, 1, g, e);      // reload column, clear latch
    bus(1'b0, 1'b0, 1, 8'h00, 6, g, e);
    check("R12 long read single advance", g, 8'h00);
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R12 following read", g, 8'h03);

    // R12 long write stores once (same byte, cell readable)
    bus(1'b0, 1'b0, 0, 8'h99, 5, g, e);
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R12 read after long write", g, 8'h03);
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R12 long write stored", g, 8'h99);

    // R11 both strobes together: no command taken
    bus(1'b0, 1'b1, 2, 8'h00, 1, g, e);
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R11 both strobes ignored", g, 8'h99);

    // R10 reset mid-run clears latch and registers
    apply_reset();
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R10 latch cleared by reset", g, 8'h00);
    bus(1'b0, 1'b0, 1, 8'h00, 1, g, e);
    check("R10 address back at (0,0)", g, 8'h5A);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule